// File: doc/BRIEF.md
# Packed Float-to-Integer Converter

This block turns two IEEE-754 single-precision numbers, packed side by side in a 64-bit word, into two signed 32-bit two's-complement integers. The two lanes are converted independently. When a value has a fractional part, a 2-bit rounding-mode input selects how it is resolved. Each lane reports an invalid flag and an inexact flag. An invalid-mask input controls what happens when a lane cannot be represented.

A conversion is requested by pulsing `issue_i` with the operands present. The results, the flags and a one-cycle `stk_reset_o` pulse appear on the next clock edge. The `stk_reset_o` pulse tells the surrounding register-stack logic to clear its 3-bit top-of-stack pointer and its 16-bit tag word to zero. When invalid is masked, a lane that cannot be represented returns the integer-indefinite pattern. When invalid is unmasked, the destination register keeps its old contents and `valid_o` stays low.

Top module: `pk_f2i_conv`

## Requirements
- R1: Source bits [31:0] convert into `result_o[31:0]` and source bits [63:32] into `result_o[63:32]`. Results and flags register on the clock edge that samples `issue_i` high, so they are visible one cycle after the request.
- R2: A finite input whose value is an integer in [-2^31, 2^31-1] converts exactly to its two's-complement value, and its inexact flag stays clear.
- R3: A value with a fractional part is rounded by `rmode_i`: 2'b00 to nearest with ties to even, 2'b01 toward negative infinity, 2'b10 toward positive infinity, 2'b11 toward zero.
- R4: A lane raises invalid when its input is NaN or infinity (exponent field all ones), or when its rounded value lies outside [-2^31, 2^31-1]. An input of exactly -2^31 is valid.
- R5: With `inv_mask_i` high, an invalid lane returns 32'h8000_0000, the other lane converts normally, and `valid_o` is high.
- R6: A lane's inexact flag is set only when the lane is not invalid and discarded fraction bits are nonzero. A zero input returns 0 with no flags. A nonzero denormal input sets inexact and returns 0 under nearest-even and toward-zero.
- R7: Every conversion request produces a one-cycle `stk_reset_o` pulse, aligned with the results, to clear the stack pointer and the tag word.
- R8: With `inv_mask_i` low and any lane invalid, `result_o` keeps its previous value and `valid_o` stays low. The invalid and inexact flags are still reported for that request.
- R9: After reset, and in any cycle that does not follow a request, `valid_o`, both flag vectors and `stk_reset_o` are low. After reset `result_o` is zero, and it changes only in a cycle where `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Conversion request |
| src_i | input | 64 | Two packed single-precision operands |
| rmode_i | input | 2 | Rounding mode |
| inv_mask_i | input | 1 | High: invalid lanes return the indefinite value |
| result_o | output | 64 | Two packed signed 32-bit results |
| valid_o | output | 1 | Result register written by the previous request |
| invalid_o | output | 2 | Per-lane invalid flag |
| inexact_o | output | 2 | Per-lane inexact flag |
| stk_reset_o | output | 1 | Stack pointer and tag word clear pulse |

## Verification
The bench builds the block with its default of two lanes, so the lane-mapping checks can catch swapped or aliased halves. Random exponents are drawn around the range where shifting and overflow decisions happen (biased exponents 100 to 170), in all four rounding modes and with both mask settings. Directed pairs then exercise the ties at plus and minus 0.5 and 2.5, the largest single value below 2^31, the signed limits ±2^31, NaN, infinity, zeros and denormals.

// File: rtl/pk_f2i_pkg.sv
package pk_f2i_pkg;
  localparam int FP_W     = 32;
  localparam int EXP_W    = 8;
  localparam int MAN_W    = 23;
  localparam int INT_W    = 32;
  localparam int BIAS     = 127;
  localparam int MAG_W    = INT_W + 1;
  // exponent at which the mantissa LSB weighs exactly 1
  localparam int SHL_BASE = BIAS + MAN_W;
  // largest left shift that can still land inside the signed range
  localparam int MAX_SHL  = INT_W - 1 - MAN_W;
  // guard bits kept below the binary point when shifting right
  localparam int GRD_W    = MAN_W + 3;
  localparam int EXT_W    = MAN_W + 1 + GRD_W;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic             invalid;
    logic             inexact;
    logic [INT_W-1:0] value;
  } lane_res_t;

  localparam logic [INT_W-1:0] INT_INDEF = {1'b1, {(INT_W-1){1'b0}}};
endpackage

// File: rtl/f2i_align.sv
module f2i_align
  import pk_f2i_pkg::*;
(
  input  logic [FP_W-1:0]  fp_i,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             rbit_o,
  output logic             sticky_o,
  output logic             huge_o
);
  logic [EXP_W-1:0] expf;
  logic [MAN_W-1:0] frac;
  logic [MAN_W:0]   mant;
  logic [EXP_W:0]   e_eff;
  logic [EXP_W:0]   shl;
  logic [EXP_W:0]   shr;
  logic [EXT_W-1:0] ext;

  always_comb begin
    sign_o   = fp_i[FP_W-1];
    expf     = fp_i[FP_W-2 -: EXP_W];
    frac     = fp_i[MAN_W-1:0];
    mant     = {|expf, frac};
    // denormals share the weight of the smallest normal exponent
    e_eff    = (expf == '0) ? (EXP_W+1)'(1) : {1'b0, expf};
    shl      = e_eff - (EXP_W+1)'(SHL_BASE);
    shr      = (EXP_W+1)'(SHL_BASE) - e_eff;
    ext      = '0;
    mag_o    = '0;
    rbit_o   = 1'b0;
    sticky_o = 1'b0;
    huge_o   = 1'b0;
    if (&expf) begin
      huge_o = 1'b1;
    end else if (e_eff >= (EXP_W+1)'(SHL_BASE)) begin
      if (shl > (EXP_W+1)'(MAX_SHL)) huge_o = 1'b1;
      else mag_o = MAG_W'(mant) << shl;
    end else if (shr > (EXP_W+1)'(GRD_W)) begin
      sticky_o = |mant;
    end else begin
      ext      = {mant, {GRD_W{1'b0}}} >> shr;
      mag_o    = MAG_W'(ext[EXT_W-1:GRD_W]);
      rbit_o   = ext[GRD_W-1];
      sticky_o = |ext[GRD_W-2:0];
    end
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import pk_f2i_pkg::*;
(
  input  logic             sign_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             rbit_i,
  input  logic             sticky_i,
  input  logic             huge_i,
  input  logic [1:0]       rmode_i,
  output lane_res_t        res_o
);
  localparam logic [MAG_W-1:0] POS_LIM = MAG_W'({1'b0, {(INT_W-1){1'b1}}});
  localparam logic [MAG_W-1:0] NEG_LIM = MAG_W'({1'b1, {(INT_W-1){1'b0}}});

  logic             lost;
  logic             inc;
  logic [MAG_W-1:0] rmag;
  logic             over;
  logic             bad;

  always_comb begin
    lost = rbit_i | sticky_i;
    unique case (rmode_e'(rmode_i))
      RM_NEAR: inc = rbit_i & (sticky_i | mag_i[0]);
      RM_DOWN: inc = lost & sign_i;
      RM_UP:   inc = lost & ~sign_i;
      default: inc = 1'b0;
    endcase
    rmag = mag_i + MAG_W'(inc);
    over = sign_i ? (rmag > NEG_LIM) : (rmag > POS_LIM);
    bad  = huge_i | over;
    res_o.invalid = bad;
    res_o.inexact = ~bad & lost;
    if (bad) res_o.value = INT_INDEF;
    else if (sign_i) res_o.value = INT_W'(-rmag);
    else res_o.value = rmag[INT_W-1:0];
  end
endmodule

// File: rtl/f2i_lane.sv
module f2i_lane
  import pk_f2i_pkg::*;
(
  input  logic [FP_W-1:0] fp_i,
  input  logic [1:0]      rmode_i,
  output lane_res_t       res_o
);
  logic             sign;
  logic [MAG_W-1:0] mag;
  logic             rbit;
  logic             sticky;
  logic             huge;

  f2i_align u_align (
    .fp_i    (fp_i),
    .sign_o  (sign),
    .mag_o   (mag),
    .rbit_o  (rbit),
    .sticky_o(sticky),
    .huge_o  (huge)
  );

  f2i_round u_round (
    .sign_i  (sign),
    .mag_i   (mag),
    .rbit_i  (rbit),
    .sticky_i(sticky),
    .huge_i  (huge),
    .rmode_i (rmode_i),
    .res_o   (res_o)
  );
endmodule

// File: rtl/pk_f2i_conv.sv
module pk_f2i_conv
  import pk_f2i_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_i,
  input  logic [LANES*FP_W-1:0]  src_i,
  input  logic [1:0]             rmode_i,
  input  logic                   inv_mask_i,
  output logic [LANES*INT_W-1:0] result_o,
  output logic                   valid_o,
  output logic [LANES-1:0]       invalid_o,
  output logic [LANES-1:0]       inexact_o,
  output logic                   stk_reset_o
);
  localparam int RES_W = LANES * INT_W;

  logic [RES_W-1:0] conv_val;
  logic [LANES-1:0] conv_inv;
  logic [LANES-1:0] conv_inx;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_res_t lres;
    f2i_lane u_lane (
      .fp_i   (src_i[g*FP_W +: FP_W]),
      .rmode_i(rmode_i),
      .res_o  (lres)
    );
    assign conv_val[g*INT_W +: INT_W] = lres.value;
    assign conv_inv[g]                = lres.invalid;
    assign conv_inx[g]                = lres.inexact;
  end

  logic             trap;
  logic             wr_en;
  logic [RES_W-1:0] res_d,   res_q;
  logic             vld_d,   vld_q;
  logic [LANES-1:0] inv_d,   inv_q;
  logic [LANES-1:0] inx_d,   inx_q;
  logic             stk_d,   stk_q;

  // next-state
  always_comb begin
    trap  = ~inv_mask_i & (|conv_inv);
    wr_en = issue_i & ~trap;
    res_d = wr_en ? conv_val : res_q;
    vld_d = wr_en;
    inv_d = issue_i ? conv_inv : '0;
    inx_d = issue_i ? conv_inx : '0;
    stk_d = issue_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
      inv_q <= '0;
      inx_q <= '0;
      stk_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
      inv_q <= inv_d;
      inx_q <= inx_d;
      stk_q <= stk_d;
    end
  end

  assign result_o    = res_q;
  assign valid_o     = vld_q;
  assign invalid_o   = inv_q;
  assign inexact_o   = inx_q;
  assign stk_reset_o = stk_q;
endmodule

// File: rtl/pk_f2i_conv_chk.sv
module pk_f2i_conv_chk
  import pk_f2i_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   issue_i,
  input logic                   inv_mask_i,
  input logic [LANES*INT_W-1:0] result_o,
  input logic                   valid_o,
  input logic [LANES-1:0]       invalid_o,
  input logic [LANES-1:0]       inexact_o,
  input logic                   stk_reset_o
);
  a_r7_stack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> stk_reset_o);

  a_r6_flags_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (invalid_o & inexact_o) == '0);

  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> result_o == $past(result_o));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!valid_o && invalid_o == '0 && inexact_o == '0 && !stk_reset_o));

  a_r8_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !inv_mask_i) |=> (!valid_o || invalid_o == '0));

  a_r8_valid_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> stk_reset_o);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    a_r5_masked_indef: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && invalid_o[g]) |-> result_o[g*INT_W +: INT_W] == INT_INDEF);
  end
endmodule

bind pk_f2i_conv pk_f2i_conv_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_i    (issue_i),
  .inv_mask_i (inv_mask_i),
  .result_o   (result_o),
  .valid_o    (valid_o),
  .invalid_o  (invalid_o),
  .inexact_o  (inexact_o),
  .stk_reset_o(stk_reset_o)
);

// File: tb/pk_f2i_conv_bench.sv
`timescale 1ns/1ps
module pk_f2i_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [63:0] src_i;
  logic [1:0]  rmode_i;
  logic        inv_mask_i;
  logic [63:0] result_o;
  logic        valid_o;
  logic [1:0]  invalid_o;
  logic [1:0]  inexact_o;
  logic        stk_reset_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [63:0] exp_res;

  always #4 clk = ~clk;

  pk_f2i_conv u_pk_f2i_conv (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .src_i(src_i),
    .rmode_i(rmode_i), .inv_mask_i(inv_mask_i), .result_o(result_o),
    .valid_o(valid_o), .invalid_o(invalid_o), .inexact_o(inexact_o),
    .stk_reset_o(stk_reset_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Reference: fixed point with 32 fraction bits, returns {invalid, inexact, value}
  function automatic logic [33:0] ref_lane(input logic [31:0] b, input logic [1:0] rm);
    logic        s;
    logic [7:0]  e;
    logic [23:0] m;
    int          ee, sh;
    logic [63:0] fx;
    logic [32:0] ip;
    logic [31:0] fr;
    logic        up, inv;
    s  = b[31];
    e  = b[30:23];
    m  = (e == 8'd0) ? {1'b0, b[22:0]} : {1'b1, b[22:0]};
    ee = (e == 8'd0) ? 1 : int'(e);
    if (e == 8'hFF) return {2'b10, 32'h8000_0000};
    sh = ee - 150 + 32;
    if (sh > 40) return {2'b10, 32'h8000_0000};
    if (sh >= 0) fx = 64'(m) << sh;
    else fx = (m != 0) ? 64'd1 : 64'd0;
    ip = {1'b0, fx[63:32]};
    fr = fx[31:0];
    case (rm)
      2'b00:   up = (fr > 32'h8000_0000) || (fr == 32'h8000_0000 && ip[0]);
      2'b01:   up = s && fr != 0;
      2'b10:   up = !s && fr != 0;
      default: up = 1'b0;
    endcase
    ip  = ip + 33'(up);
    inv = s ? (ip > 33'h0_8000_0000) : (ip > 33'h0_7FFF_FFFF);
    if (inv) return {2'b10, 32'h8000_0000};
    return {1'b0, fr != 0, s ? 32'(-ip) : ip[31:0]};
  endfunction

  task automatic conv(input logic [63:0] src, input logic [1:0] rm, input bit mask, input string tag);
    logic [33:0] l0, l1;
    bit          trap;
    l0   = ref_lane(src[31:0], rm);
    l1   = ref_lane(src[63:32], rm);
    trap = !mask && (l0[33] || l1[33]);
    if (!trap) exp_res = {l1[31:0], l0[31:0]};
    @(negedge clk);
    src_i = src; rmode_i = rm; inv_mask_i = mask; issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    chk(result_o == exp_res, {tag, " R1 result"}, result_o, exp_res);
    chk(valid_o == !trap, {tag, " R8 valid"}, 64'(valid_o), 64'(!trap));
    chk(invalid_o == {l1[33], l0[33]}, {tag, " R4 invalid"}, 64'(invalid_o), 64'({l1[33], l0[33]}));
    chk(inexact_o == {l1[32], l0[32]}, {tag, " R6 inexact"}, 64'(inexact_o), 64'({l1[32], l0[32]}));
    chk(stk_reset_o == 1'b1, {tag, " R7 stack"}, 64'(stk_reset_o), 64'd1);
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(!valid_o && invalid_o == 0 && inexact_o == 0 && !stk_reset_o, "R9 idle quiet",
        {valid_o, stk_reset_o, invalid_o, inexact_o}, 64'd0);
    chk(result_o == exp_res, "R9 result held while idle", result_o, exp_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rnd[2];
    void'($urandom(32'd5529));
    rst_n = 1'b0; issue_i = 1'b0; src_i = '0; rmode_i = 2'b00; inv_mask_i = 1'b1;
    exp_res = '0;
    repeat (3) @(negedge clk);
    chk(result_o == 0 && !valid_o && invalid_o == 0 && inexact_o == 0 && !stk_reset_o,
        "R9 reset state", result_o, 64'd0);
    rst_n = 1'b1;
    idle_check();

    // R2 exact integers, lane mapping R1: lane0 = 100.0, lane1 = -7.0
    conv({32'hC0E0_0000, 32'h42C8_0000}, 2'b00, 1'b1, "R2 exact");
    idle_check();
    // R3 ties and halves in all modes
    for (int m = 0; m < 4; m++) begin
      conv({32'h4020_0000, 32'h4060_0000}, 2'(m), 1'b1, "R3 2.5/3.5");
      conv({32'hBF00_0000, 32'hC020_0000}, 2'(m), 1'b1, "R3 -0.5/-2.5");
      conv({32'h3F80_0000, 32'h3F00_0000}, 2'(m), 1'b1, "R3 0.5/1.0");
      conv({32'h8000_0001, 32'h0000_0001}, 2'(m), 1'b1, "R6 denormals");
    end
    // R4 limits: +2^31 invalid, -2^31 valid; largest below 2^31
    conv({32'hCF00_0000, 32'h4F00_0000}, 2'b00, 1'b1, "R4 R5 +-2^31");
    conv({32'hCEFF_FFFF, 32'h4EFF_FFFF}, 2'b10, 1'b1, "R4 near limit");
    conv({32'h7F80_0000, 32'h7FC0_0000}, 2'b11, 1'b1, "R4 R5 nan/inf");
    conv({32'h8000_0000, 32'h0000_0000}, 2'b01, 1'b1, "R6 zeros");
    // R8 unmasked invalid keeps old result
    conv({32'h3F80_0000, 32'hFF80_0000}, 2'b00, 1'b0, "R8 unmasked");
    idle_check();
    conv({32'h4060_0000, 32'h4F80_0000}, 2'b11, 1'b0, "R8 unmasked big");

    for (int i = 0; i < 3000; i++) begin
      for (int k = 0; k < 2; k++) begin
        rnd[k] = $urandom;
        if ($urandom_range(9) != 0)
          rnd[k][30:23] = 8'($urandom_range(170, 100));
      end
      conv({rnd[1], rnd[0]}, 2'($urandom_range(3)), 1'($urandom_range(3) != 0), "R3 random");
    end
    idle_check();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule